// File: doc/BRIEF.md
# Predicated Register-Vector Add Sequencer

This block is a hardware loop that takes one add operation written with scalar register numbers and runs it as a series of element adds over consecutive registers of an ordinary 32-entry integer register file. The caller gives a destination, two source registers and a predicate register. A per-register table gives each register a vector length and a flag that marks it as vectorised. A global vector length register caps the loop. The sequencer then issues one element add per clock. It steps the destination, source 1 and source 2 register numbers separately, and it steps a register number only when that register is flagged as vectorised. So scalar-scalar, scalar-vector and vector-vector adds all use the same datapath.

Each bit of the predicate register enables one element. Element i runs only when bit i is set. A masked-off element is skipped completely, and its destination keeps its old value. The register file, the length and flag table and the global length are loaded through simple write ports. A debug read port lets the contents of any register be observed. Every element write also appears on an element-write output, so a monitor can follow the loop as it runs.

Top module: `vec_add_seq`

## Requirements
- R1: After reset, busy, done and ew_valid are low, every register reads zero on the debug port, and the global length, every table length and every table flag are zero.
- R2: An accepted start runs N = min(global length, length of rd in the table, 32) elements. busy is high for exactly N cycles, starting in the cycle after start. done is high for exactly one cycle, the cycle right after the last element.
- R3: Element i (counting from 0) produces a write only when bit i of the predicate register is set. The predicate is the register's value in the cycle of the accepted start.
- R4: A masked-off element writes nothing. Its destination register keeps its earlier value, and no zero is written.
- R5: The destination, source 1 and source 2 register numbers each advance by one per element only when that register's table flag is 1. Otherwise the same register is used for every element. The offsets advance on every element, whether or not that element is masked.
- R6: Element i writes register (rd + offset_d) mod 32 with the value reg[(rs1 + offset_1) mod 32] + reg[(rs2 + offset_2) mod 32], taken mod 2^32. ew_addr and ew_data show this write in the cycle it happens.
- R7: Register 0 always reads zero and ignores writes from both the host port and the element loop.
- R8: When N is zero, done is high in the cycle after start, busy stays low, and no register is written.
- R9: While busy is high, start is ignored and so are host register writes. The running loop keeps the register numbers it latched at its own start.
- R10: Each element reads its sources after the writes of all earlier elements of the same run, so a source that overlaps the destination sees the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vl_we | input | 1 | Write enable for the global vector length |
| vl_wdata | input | 6 | New global vector length |
| cfg_we | input | 1 | Write enable for one table entry |
| cfg_reg | input | 5 | Register number of the table entry |
| cfg_len | input | 6 | Vector length stored for that register |
| cfg_vec | input | 1 | Vectorised flag stored for that register |
| rf_we | input | 1 | Host register write enable (ignored while busy) |
| rf_waddr | input | 5 | Host register write address |
| rf_wdata | input | 32 | Host register write data |
| dbg_raddr | input | 5 | Debug read address |
| dbg_rdata | output | 32 | Debug read data (combinational) |
| start | input | 1 | Start pulse (ignored while busy) |
| op_rd | input | 5 | Destination base register |
| op_rs1 | input | 5 | Source 1 base register |
| op_rs2 | input | 5 | Source 2 base register |
| op_pred | input | 5 | Predicate register number |
| busy | output | 1 | High while elements are being issued |
| done | output | 1 | One-cycle completion pulse |
| ew_valid | output | 1 | An element write happens this cycle |
| ew_addr | output | 5 | Register written by the element |
| ew_data | output | 32 | Value written by the element |

## Verification
If an offset counter or the element index is wrong inside the loop, the very next enabled element shows the wrong ew_addr or ew_data. The scoreboard catches that in the same cycle, before the run ends. If the predicate or the count is latched wrongly, elements go missing or extra ones appear, and busy lasts the wrong number of cycles. This shows up at done, one cycle after the last element. A write that damages a register the element stream does not show, such as a masked destination or register 0, only appears when the whole register file is compared on the debug port after each run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   // operand slot numbering shared by the loop and the top level
   localparam int SLOT_D  = 0;
   localparam int SLOT_S1 = 1;
   localparam int SLOT_S2 = 2;
   localparam int NSLOT   = 3;

   function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/vseq_regfile.sv
module vseq_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int NRD  = 4,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [XLEN-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][XLEN-1:0]  rdata
);
   logic [XLEN-1:0] rv [NREG];

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("vseq_regfile: NREG must be a power of two, at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("vseq_regfile: at least one read port is needed");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign rv[i] = '0;
      end else begin : g_store
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == AW'(i))
               q <= wdata;
         end
         assign rv[i] = q;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata[r] = rv[raddr[r]];
   end
endmodule

// File: rtl/vseq_cfg.sv
module vseq_cfg #(
   parameter int NREG = 32,
   parameter int LW   = 6,
   parameter int NQ   = 3,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [AW-1:0]          cfg_reg,
   input  logic [LW-1:0]          cfg_len,
   input  logic                   cfg_vec,
   input  logic                   vl_we,
   input  logic [LW-1:0]          vl_wdata,
   input  logic [NQ-1:0][AW-1:0]  q_idx,
   output logic [LW-1:0]          len_q0,
   output logic [NQ-1:0]          vec_q,
   output logic [LW-1:0]          vl
);
   logic [LW-1:0] len_tab [NREG];
   logic          vec_tab [NREG];

   if (LW < 1) begin : g_bad_lw
      $error("vseq_cfg: LW must be positive");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_tab[i] <= '0;
            vec_tab[i] <= 1'b0;
         end else if (cfg_we && cfg_reg == AW'(i)) begin
            len_tab[i] <= cfg_len;
            vec_tab[i] <= cfg_vec;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vl <= '0;
      else if (vl_we)
         vl <= vl_wdata;
   end

   assign len_q0 = len_tab[q_idx[0]];
   for (genvar k = 0; k < NQ; k++) begin : g_q
      assign vec_q[k] = vec_tab[q_idx[k]];
   end
endmodule

// File: rtl/vseq_loop.sv
module vseq_loop
   import vseq_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG),
   localparam int IW  = $clog2(XLEN),
   localparam int LW  = $clog2(XLEN + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NSLOT-1:0][AW-1:0] base_in,
   input  logic [NSLOT-1:0]         vec_in,
   input  logic [XLEN-1:0]          pred_in,
   input  logic [LW-1:0]            vl,
   input  logic [LW-1:0]            len_rd,
   output logic                     busy,
   output logic                     done,
   output logic                     elem_en,
   output logic [NSLOT-1:0][AW-1:0] addr_out
);
   logic              busy_q, done_q, accept, last;
   logic [XLEN-1:0]   pred_q;
   logic [IW-1:0]     idx_q;
   logic [LW-1:0]     cnt_q, m1, cnt_in;
   logic [NSLOT-1:0][AW-1:0] base_q, off_q;
   logic [NSLOT-1:0]         vec_q;

   always_comb begin
      m1     = (vl < len_rd) ? vl : len_rd;
      cnt_in = (m1 > LW'(XLEN)) ? LW'(XLEN) : m1;
   end

   assign accept = start && !busy_q;
   assign last   = (LW'(idx_q) + LW'(1)) == cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         pred_q <= '0;
      end else if (accept) begin
         idx_q  <= '0;
         cnt_q  <= cnt_in;
         pred_q <= pred_in;
         busy_q <= (cnt_in != '0);
         done_q <= (cnt_in == '0);
      end else if (busy_q) begin
         idx_q  <= idx_q + IW'(1);
         busy_q <= !last;
         done_q <= last;
      end else begin
         done_q <= 1'b0;
      end
   end

   // one offset counter per operand slot; a scalar slot never moves
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[k] <= '0;
            vec_q[k]  <= 1'b0;
            off_q[k]  <= '0;
         end else if (accept) begin
            base_q[k] <= base_in[k];
            vec_q[k]  <= vec_in[k];
            off_q[k]  <= '0;
         end else if (busy_q && vec_q[k]) begin
            off_q[k]  <= off_q[k] + AW'(1);
         end
      end
      assign addr_out[k] = base_q[k] + off_q[k];

      // R5
      scalar_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && !vec_q[k]) |-> (off_q[k] == '0));
   end

   assign elem_en = busy_q && pred_q[idx_q];
   assign busy    = busy_q;
   assign done    = done_q;

   // R2
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));
   // R2
   end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   // R8
   empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt_in == '0) |=> (done_q && !busy_q));
   // R9
   hold_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> $stable(base_q));
endmodule

// File: rtl/vec_add_seq.sv
module vec_add_seq
   import vseq_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG),
   localparam int LW  = $clog2(XLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vl_we,
   input  logic [LW-1:0]   vl_wdata,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_reg,
   input  logic [LW-1:0]   cfg_len,
   input  logic            cfg_vec,
   input  logic            rf_we,
   input  logic [AW-1:0]   rf_waddr,
   input  logic [XLEN-1:0] rf_wdata,
   input  logic [AW-1:0]   dbg_raddr,
   output logic [XLEN-1:0] dbg_rdata,
   input  logic            start,
   input  logic [AW-1:0]   op_rd,
   input  logic [AW-1:0]   op_rs1,
   input  logic [AW-1:0]   op_rs2,
   input  logic [AW-1:0]   op_pred,
   output logic            busy,
   output logic            done,
   output logic            ew_valid,
   output logic [AW-1:0]   ew_addr,
   output logic [XLEN-1:0] ew_data
);
   localparam int NRD = 4;

   if ((1 << $clog2(XLEN)) != XLEN) begin : g_bad_xlen
      $error("vec_add_seq: XLEN must be a power of two");
   end

   logic [NSLOT-1:0][AW-1:0] base_in, addr;
   logic [NSLOT-1:0]         vec_in;
   logic [LW-1:0]            len_rd, vl;
   logic                     elem_en, busy_i;
   logic [NRD-1:0][AW-1:0]   raddr;
   logic [NRD-1:0][XLEN-1:0] rdata;
   logic                     we;
   logic [AW-1:0]            waddr;
   logic [XLEN-1:0]          wdata, sum;

   assign base_in = {op_rs2, op_rs1, op_rd};

   vseq_cfg #(.NREG(NREG), .LW(LW), .NQ(NSLOT)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_len(cfg_len), .cfg_vec(cfg_vec),
      .vl_we(vl_we), .vl_wdata(vl_wdata),
      .q_idx(base_in), .len_q0(len_rd), .vec_q(vec_in), .vl(vl)
   );

   vseq_loop #(.XLEN(XLEN), .NREG(NREG)) u_loop (
      .clk(clk), .rst_n(rst_n), .start(start),
      .base_in(base_in), .vec_in(vec_in), .pred_in(rdata[2]),
      .vl(vl), .len_rd(len_rd),
      .busy(busy_i), .done(done), .elem_en(elem_en), .addr_out(addr)
   );

   assign raddr[0] = addr[SLOT_S1];
   assign raddr[1] = addr[SLOT_S2];
   assign raddr[2] = op_pred;
   assign raddr[3] = dbg_raddr;
   assign sum      = rdata[0] + rdata[1];

   always_comb begin
      if (elem_en) begin
         we = 1'b1; waddr = addr[SLOT_D]; wdata = sum;
      end else begin
         we = rf_we && !busy_i; waddr = rf_waddr; wdata = rf_wdata;
      end
   end

   vseq_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata)
   );

   assign busy      = busy_i;
   assign dbg_rdata = rdata[3];
   assign ew_valid  = elem_en;
   assign ew_addr   = addr[SLOT_D];
   assign ew_data   = sum;

   // R3
   elem_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ew_valid |-> busy);
   // R7
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_raddr == '0) |-> (dbg_rdata == '0));
endmodule

// File: tb/test_vec_add_seq.sv
`timescale 1ns/1ps
module test_vec_add_seq;
   logic        clk = 0, rst_n = 0;
   logic        vl_we = 0, cfg_we = 0, cfg_vec = 0, rf_we = 0, start = 0;
   logic [5:0]  vl_wdata = 0, cfg_len = 0;
   logic [4:0]  cfg_reg = 0, rf_waddr = 0, dbg_raddr = 0;
   logic [4:0]  op_rd = 0, op_rs1 = 0, op_rs2 = 0, op_pred = 0;
   logic [31:0] rf_wdata = 0, dbg_rdata, ew_data;
   logic        busy, done, ew_valid;
   logic [4:0]  ew_addr;

   int total = 0, bad = 0;
   logic [31:0] m_rf [32];
   int          m_len [32];
   bit          m_vec [32];
   int          m_vl = 0;
   logic [36:0] exp_q [$];   // {addr, data}

   always #10 clk = ~clk;

   vec_add_seq i_vec_add_seq (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: compares element writes against the scoreboard
   always @(negedge clk) begin
      if (rst_n && ew_valid) begin
         if (exp_q.size() == 0)
            chk(0, "R3", "unexpected element write", {ew_addr, ew_data}, 0);
         else begin
            logic [36:0] e;
            e = exp_q.pop_front();
            chk({ew_addr, ew_data} == e, "R6", "element write", {ew_addr, ew_data}, e);
         end
      end
   end

   task automatic wr_reg(input int a, input logic [31:0] d);
      @(negedge clk); rf_we = 1; rf_waddr = 5'(a); rf_wdata = d;
      @(negedge clk); rf_we = 0;
      if (a != 0) m_rf[a] = d;
   endtask

   task automatic set_cfg(input int r, input int len, input bit v);
      @(negedge clk); cfg_we = 1; cfg_reg = 5'(r); cfg_len = 6'(len); cfg_vec = v;
      @(negedge clk); cfg_we = 0;
      m_len[r] = len; m_vec[r] = v;
   endtask

   task automatic set_vl(input int v);
      @(negedge clk); vl_we = 1; vl_wdata = 6'(v);
      @(negedge clk); vl_we = 0;
      m_vl = v;
   endtask

   task automatic chk_rf(input string tag);
      for (int a = 0; a < 32; a++) begin
         @(negedge clk); dbg_raddr = 5'(a);
         #1 chk(dbg_rdata == m_rf[a], tag, $sformatf("reg %0d", a), dbg_rdata, m_rf[a]);
      end
   endtask

   // driver: builds the expected element stream, then starts the run
   task automatic run_op(input int rd, input int rs1, input int rs2, input int pr,
                         input bit poke, input string tag);
      int n, od = 0, o1 = 0, o2 = 0, cyc = 0;
      logic [31:0] pv;
      n = (m_vl < m_len[rd]) ? m_vl : m_len[rd];
      if (n > 32) n = 32;
      pv = m_rf[pr];
      for (int i = 0; i < n; i++) begin
         int d, a1, a2;
         logic [31:0] v;
         d = (rd + od) % 32; a1 = (rs1 + o1) % 32; a2 = (rs2 + o2) % 32;
         if (pv[i]) begin
            v = m_rf[a1] + m_rf[a2];
            exp_q.push_back({5'(d), v});
            if (d != 0) m_rf[d] = v;
         end
         if (m_vec[rd]) od++;
         if (m_vec[rs1]) o1++;
         if (m_vec[rs2]) o2++;
      end
      @(negedge clk);
      start = 1; op_rd = 5'(rd); op_rs1 = 5'(rs1); op_rs2 = 5'(rs2); op_pred = 5'(pr);
      @(negedge clk);
      start = 0;
      while (busy) begin
         cyc++;
         if (poke && cyc == 1) begin
            start = 1; op_rd = 5'd7; op_rs1 = 5'd8; op_rs2 = 5'd9;
            rf_we = 1; rf_waddr = 5'd25; rf_wdata = 32'hDEAD_BEEF;
         end else begin
            start = 0; rf_we = 0;
         end
         @(negedge clk);
      end
      start = 0; rf_we = 0;
      chk(cyc == n, "R2", {tag, " busy cycles"}, cyc, n);
      chk(done == 1'b1, "R2", {tag, " done after last"}, done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R2", {tag, " done single pulse"}, done, 0);
      chk(exp_q.size() == 0, "R3", {tag, " missing element writes"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < 32; a++) begin m_rf[a] = 0; m_len[a] = 0; m_vec[a] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && done == 0 && ew_valid == 0, "R1", "outputs after reset",
          {busy, done, ew_valid}, 0);
      rst_n = 1;
      chk_rf("R1");
      // R1/R8: untouched length and table give an empty run
      run_op(3, 1, 2, 0, 0, "R1 empty config");

      // R7: register 0 ignores a host write
      wr_reg(0, 32'h1234_5678);
      for (int a = 1; a < 24; a++) wr_reg(a, 32'(a * 32'h0101_0011));
      wr_reg(30, 32'hFFFF_FFFF);
      wr_reg(29, 32'h0000_000A);   // mask 1010
      chk_rf("R7");

      // R5/R6: vector-vector, count limited by rd length (4 < VL 8)
      set_vl(8);
      set_cfg(10, 4, 1); set_cfg(1, 8, 1); set_cfg(5, 8, 1);
      run_op(10, 1, 5, 30, 0, "R6 vv");
      chk_rf("R6");

      // R3/R4: masked elements leave destinations unchanged
      run_op(10, 5, 1, 29, 0, "R4 masked");
      chk_rf("R4");

      // R5: scalar second source, count limited by VL (3 < len 6)
      set_vl(3);
      set_cfg(14, 6, 1); set_cfg(20, 1, 0);
      run_op(14, 1, 20, 30, 0, "R5 sv");
      chk_rf("R5");

      // R10: scalar dest equals scalar source, accumulates across elements
      set_cfg(21, 3, 0); set_cfg(22, 1, 0);
      run_op(21, 21, 22, 30, 0, "R10 accum");
      chk_rf("R10");

      // R8: zero global length
      set_vl(0);
      run_op(10, 1, 5, 30, 0, "R8 vl zero");
      chk_rf("R8");

      // R9: start and host write during a run are ignored
      set_vl(5);
      set_cfg(2, 5, 1);
      run_op(2, 1, 5, 30, 1, "R9 busy poke");
      chk_rf("R9");

      // R2/R6/R7: lengths above 32 clamp; destination wraps through register 0
      set_vl(63);
      set_cfg(16, 63, 1); set_cfg(3, 63, 1);
      run_op(16, 3, 30, 30, 0, "R2 clamp wrap");
      chk_rf("R7 wrap");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule